// File: doc/BRIEF.md
# Parallel SAR Converter Capture Controller

This controller runs an external successive-approximation converter that has a 12-bit parallel data bus. It holds the converter's active-low select line low while it is enabled. At a programmable sample period, counted in system-clock cycles, it pulses the active-low start line. It watches the converter's active-low busy line through a synchronizer. Each captured word is sign-extended from 12-bit two's complement to 16 bits and offered on a valid/ready stream, ready to feed a FIFO.

The word is taken when the synchronized busy line falls, which is the start of a conversion. At that moment the bus still holds the result of the previous conversion. Each emitted sample therefore trails its conversion by one start. The first word captured after enable is stale, so the controller discards it. A new start is never issued while the converter is still converting. A sample that arrives while the previous one has not been accepted sets a sticky overflow flag. A converter that never finishes sets a sticky timeout flag.

Top module: `adc_capture_ctrl`

## Requirements
- R1: While reset is held, select and start are high (inactive), `smp_valid` is low and both flags are low.
- R2: `adc_cs_n` is low exactly while `enable` is high, delayed by one cycle. A falling edge of `adc_convst_n` only occurs when `adc_cs_n` was already low in the previous cycle.
- R3: Each start pulse holds `adc_convst_n` low for exactly `PULSE_CYC` cycles (default 1 cycle, 20 ns at 50 MHz).
- R4: Successive start falling edges are spaced by max(`period`, `MIN_PERIOD`) cycles (default minimum 17 cycles, at least 333 ns), provided each conversion completes within that spacing.
- R5: No start is issued while the synchronized `adc_busy_n` is low (0 = converting).
- R6: Words are captured on the synchronized falling edge of `adc_busy_n`, never on its rising edge. The first capture after enable is discarded. Every later sample equals the result of the conversion before the one during which it was captured, in order.
- R7: `smp_data[15:12]` copies bit 11 of the captured word, and `smp_data[11:0]` equals the word, so 0x800 gives 0xF800 and 0x7FF gives 0x07FF.
- R8: Once raised, `smp_valid` stays high with `smp_data` unchanged until `smp_ready` is high.
- R9: A capture that arrives while `smp_valid` is high and `smp_ready` is low is dropped and sets `overflow`. The flag stays set until `enable` goes low.
- R10: If `adc_busy_n` has not returned high within `TIMEOUT_CYC` cycles (default 64) after a start, `timeout_err` is set and stays set until disable. The controller then returns to idle and retries at the next period tick.
- R11: One cycle after `enable` is low, select and start are high, `smp_valid` is low and both flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run sampling; low aborts and clears flags |
| period | input | 16 | Start-to-start spacing in clock cycles |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_convst_n | output | 1 | Conversion start, falling edge starts |
| adc_busy_n | input | 1 | Converter status, low while converting |
| adc_data | input | 12 | Converter parallel data, two's complement |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Downstream accepts sample |
| smp_data | output | 16 | Sign-extended sample |
| overflow | output | 1 | Sticky: a sample was dropped |
| timeout_err | output | 1 | Sticky: a conversion never completed |

## Verification
The assertions assume the converter pulls `adc_busy_n` low within a few cycles of a start and holds its data bus steady while converting. They also assume `smp_ready` only affects the stream handshake. The bench's converter model honours these rules: busy falls one clock after it sees the start, the data changes only as busy rises, and the model reports any start that violates the select, busy or pulse-width rules. A mute mode that ignores starts is the only departure, and it is used solely to provoke the timeout.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT_FALL,
        ST_WAIT_RISE
    } cap_state_t;
endpackage

// File: rtl/cap_busy_sync.sv
module cap_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_n_in,
    output logic idle_s,
    output logic fell,
    output logic rose
);
    // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], busy_n_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign idle_s = sh_q[STAGES-1];
    assign fell   = sh_q[STAGES] & ~sh_q[STAGES-1];
    assign rose   = ~sh_q[STAGES] & sh_q[STAGES-1];
endmodule

// File: rtl/cap_period_timer.sv
module cap_period_timer #(
    parameter int PERIOD_W   = 16,
    parameter int MIN_PERIOD = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);
    localparam logic [PERIOD_W-1:0] MIN_P = PERIOD_W'(MIN_PERIOD);

    logic [PERIOD_W-1:0] cnt_d, cnt_q;
    logic [PERIOD_W-1:0] eff;

    always_comb begin
        eff   = (period < MIN_P) ? MIN_P : period;
        tick  = run && (cnt_q == '0);
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = eff - 1'b1;
        else           cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4
endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl
    import adc_cap_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int OUT_W       = 16,
    parameter int PERIOD_W    = 16,
    parameter int MIN_PERIOD  = 17,
    parameter int PULSE_CYC   = 1,
    parameter int TIMEOUT_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period,
    output logic                adc_cs_n,
    output logic                adc_convst_n,
    input  logic                adc_busy_n,
    input  logic [DATA_W-1:0]   adc_data,
    output logic                smp_valid,
    input  logic                smp_ready,
    output logic [OUT_W-1:0]    smp_data,
    output logic                overflow,
    output logic                timeout_err
);
    localparam int PCNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam int TMO_W  = $clog2(TIMEOUT_CYC + 1);
    localparam int EXT_W  = OUT_W - DATA_W;

    typedef struct packed {
        cap_state_t         st;
        logic               cs_n;
        logic               convst_n;
        logic [PCNT_W-1:0]  pcnt;
        logic               fell_seen;
        logic [TMO_W-1:0]   tmo;
        logic               first;
        logic               valid;
        logic [OUT_W-1:0]   data;
        logic               ovf;
        logic               tmo_err;
    } regs_t;

    regs_t r_d, r_q;
    logic  b_idle, b_fell, b_rose, tick, run;

    cap_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .busy_n_in(adc_busy_n),
        .idle_s(b_idle), .fell(b_fell), .rose(b_rose)
    );

    assign run = enable && !r_q.cs_n;

    cap_period_timer #(.PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .period(period), .tick(tick)
    );

    always_comb begin
        r_d = r_q;
        if (!enable) begin
            r_d.st        = ST_IDLE;
            r_d.cs_n      = 1'b1;
            r_d.convst_n  = 1'b1;
            r_d.first     = 1'b1;
            r_d.valid     = 1'b0;
            r_d.ovf       = 1'b0;
            r_d.tmo_err   = 1'b0;
            r_d.fell_seen = 1'b0;
        end else begin
            r_d.cs_n = 1'b0;
            if (r_q.valid && smp_ready) r_d.valid = 1'b0;
            // capture: bus still shows the previous conversion's result
            if (b_fell && r_q.st != ST_IDLE) begin
                if (r_q.first) begin
                    r_d.first = 1'b0;
                end else if (r_q.valid && !smp_ready) begin
                    r_d.ovf = 1'b1;
                end else begin
                    r_d.valid = 1'b1;
                    r_d.data  = {{EXT_W{adc_data[DATA_W-1]}}, adc_data};
                end
            end
            case (r_q.st)
                ST_IDLE: begin
                    if (tick && b_idle) begin
                        r_d.st        = ST_PULSE;
                        r_d.convst_n  = 1'b0;
                        r_d.pcnt      = '0;
                        r_d.tmo       = '0;
                        r_d.fell_seen = 1'b0;
                    end
                end
                ST_PULSE: begin
                    r_d.tmo = r_q.tmo + 1'b1;
                    if (b_fell) r_d.fell_seen = 1'b1;
                    if (r_q.pcnt == PCNT_W'(PULSE_CYC - 1)) begin
                        r_d.convst_n = 1'b1;
                        r_d.st = (r_q.fell_seen || b_fell) ? ST_WAIT_RISE : ST_WAIT_FALL;
                    end else begin
                        r_d.pcnt = r_q.pcnt + 1'b1;
                    end
                end
                ST_WAIT_FALL: begin
                    r_d.tmo = r_q.tmo + 1'b1;
                    if (b_fell) r_d.st = ST_WAIT_RISE;
                end
                default: begin
                    r_d.tmo = r_q.tmo + 1'b1;
                    if (b_rose) r_d.st = ST_IDLE;
                end
            endcase
            if (r_q.st != ST_IDLE && r_q.tmo == TMO_W'(TIMEOUT_CYC - 1)) begin
                r_d.st       = ST_IDLE;
                r_d.convst_n = 1'b1;
                r_d.tmo_err  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.st        <= ST_IDLE;
            r_q.cs_n      <= 1'b1;
            r_q.convst_n  <= 1'b1;
            r_q.first     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign adc_cs_n     = r_q.cs_n;
    assign adc_convst_n = r_q.convst_n;
    assign smp_valid    = r_q.valid;
    assign smp_data     = r_q.data;
    assign overflow     = r_q.ovf;
    assign timeout_err  = r_q.tmo_err;

    AST_START_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_convst_n) |-> !$past(adc_cs_n)); // R2
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_convst_n) |-> $past(b_idle)); // R5
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready && enable) |=> (smp_valid && $stable(smp_data))); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && enable) |=> overflow); // R9
    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_err && enable) |=> timeout_err); // R10
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (adc_cs_n && adc_convst_n && !smp_valid && !overflow && !timeout_err)); // R11
endmodule

// File: tb/adc_capture_ctrl_bench.sv
module adc_capture_ctrl_bench;
    localparam int CONV_CYC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] period = 16'd20;
    logic        adc_cs_n, adc_convst_n;
    logic        adc_busy_n;
    logic [11:0] adc_data;
    logic        smp_valid;
    logic        smp_ready = 1'b1;
    logic [15:0] smp_data;
    logic        overflow, timeout_err;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    adc_capture_ctrl u_adc_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
        .adc_cs_n(adc_cs_n), .adc_convst_n(adc_convst_n),
        .adc_busy_n(adc_busy_n), .adc_data(adc_data),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
        .overflow(overflow), .timeout_err(timeout_err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] conv_result(input int n);
        case (n % 5)
            0: return 12'h7FF;
            1: return 12'h800;
            2: return 12'hFFF;
            3: return 12'h001;
            default: return 12'(n * 37);
        endcase
    endfunction

    function automatic logic [15:0] sext(input logic [11:0] v);
        return {{4{v[11]}}, v};
    endfunction

    // behavioral converter model
    logic [11:0] results[$];
    logic mute = 1'b0;
    logic cv_prev;
    int   conv_left;
    int   nconv = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            adc_busy_n <= 1'b1;
            adc_data   <= 12'hABC;
            cv_prev    <= 1'b1;
            conv_left  <= 0;
        end else begin
            cv_prev <= adc_convst_n;
            if (cv_prev && !adc_convst_n) begin
                chk(!adc_cs_n, "R2 start without select", {31'd0, adc_cs_n}, 32'd0);
                chk(adc_busy_n, "R5 start while converting", {31'd0, adc_busy_n}, 32'd1);
                if (!mute && adc_busy_n) begin
                    adc_busy_n <= 1'b0;
                    conv_left  <= CONV_CYC - 1;
                end
            end else if (!adc_busy_n) begin
                if (conv_left == 0) begin
                    adc_busy_n <= 1'b1;
                    adc_data   <= conv_result(nconv);
                    results.push_back(conv_result(nconv));
                    nconv++;
                end else begin
                    conv_left <= conv_left - 1;
                end
            end
        end
    end

    // monitors, sampled at the falling edge
    int  cyc = 0;
    int  starts = 0;
    int  last_fall = 0;
    int  last_gap = 0;
    int  low_len = 0;
    int  emitted = 0;
    logic mon_cv = 1'b1;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_cv && !adc_convst_n) begin
                starts++;
                last_gap  = cyc - last_fall;
                last_fall = cyc;
                low_len   = 0;
            end
            if (!adc_convst_n) low_len++;
            if (!mon_cv && adc_convst_n)
                chk(low_len == 1, "R3 start pulse width", low_len, 1);
            mon_cv = adc_convst_n;
            if (smp_valid && smp_ready) begin
                emitted++;
                if (results.size() == 0) begin
                    chk(1'b0, "R6 sample with no finished conversion", {16'd0, smp_data}, 0);
                end else begin
                    logic [11:0] e;
                    e = results.pop_front();
                    chk(smp_data == sext(e), "R6 R7 sample value", {16'd0, smp_data}, {16'd0, sext(e)});
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_session(input logic [15:0] p, input logic rdy);
        while (!adc_busy_n) @(negedge clk);
        results.delete();
        period    = p;
        smp_ready = rdy;
        emitted   = 0;
        enable    = 1'b1;
    endtask

    task automatic end_session();
        enable = 1'b0;
        @(negedge clk);
        chk(adc_cs_n && adc_convst_n, "R11 select and start released",
            {30'd0, adc_cs_n, adc_convst_n}, 32'd3);
        chk(!smp_valid && !overflow && !timeout_err, "R11 outputs and flags cleared",
            {29'd0, smp_valid, overflow, timeout_err}, 0);
        wait_cyc(40);
        smp_ready = 1'b1;
    endtask

    task automatic t_reset();
        wait_cyc(3);
        chk(adc_cs_n && adc_convst_n, "R1 select and start idle in reset",
            {30'd0, adc_cs_n, adc_convst_n}, 32'd3);
        chk(!smp_valid && !overflow && !timeout_err, "R1 valid and flags low in reset",
            {29'd0, smp_valid, overflow, timeout_err}, 0);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic t_stream();
        int s0;
        begin_session(16'd25, 1'b1);
        @(negedge clk);
        @(negedge clk);
        chk(!adc_cs_n, "R2 select low while enabled", {31'd0, adc_cs_n}, 0);
        s0 = starts;
        while (starts < s0 + 10) @(negedge clk);
        chk(last_gap == 25, "R4 start spacing at period 25", last_gap, 25);
        wait_cyc(20);
        // ten starts: first capture dropped, tenth result not yet captured
        chk(emitted == 9, "R6 first word dropped, rest emitted", emitted, 9);
        end_session();
    endtask

    task automatic t_clamp();
        int s0;
        begin_session(16'd5, 1'b1);
        wait_cyc(2);
        s0 = starts;
        while (starts < s0 + 6) @(negedge clk);
        chk(last_gap == 17, "R4 period below minimum clamped", last_gap, 17);
        chk(timeout_err == 1'b0, "R10 no timeout on healthy converter", {31'd0, timeout_err}, 0);
        end_session();
    endtask

    task automatic t_backpressure();
        logic [15:0] held;
        begin_session(16'd20, 1'b0);
        wait_cyc(140);
        chk(smp_valid, "R8 sample held without ready", {31'd0, smp_valid}, 1);
        chk(results.size() > 0 && smp_data == sext(results[0]), "R8 held sample is oldest result",
            {16'd0, smp_data}, (results.size() > 0) ? {16'd0, sext(results[0])} : 0);
        chk(overflow, "R9 overflow after dropped sample", {31'd0, overflow}, 1);
        held = smp_data;
        wait_cyc(30);
        chk(smp_valid && smp_data == held, "R8 data stable while stalled", {16'd0, smp_data}, {16'd0, held});
        chk(overflow, "R9 overflow stays set", {31'd0, overflow}, 1);
        end_session();
    endtask

    task automatic t_timeout();
        int s0;
        mute = 1'b1;
        begin_session(16'd20, 1'b1);
        wait_cyc(2);
        s0 = starts;
        wait_cyc(160);
        chk(timeout_err, "R10 timeout flag raised", {31'd0, timeout_err}, 1);
        chk(starts >= s0 + 2, "R10 controller retries after timeout", starts - s0, 2);
        chk(emitted == 0, "R10 no samples without conversions", emitted, 0);
        end_session();
        mute = 1'b0;
    endtask

    task automatic t_reenable();
        int s0;
        begin_session(16'd18, 1'b1);
        s0 = starts;
        while (starts < s0 + 5) @(negedge clk);
        wait_cyc(20);
        chk(emitted == 4, "R6 stale word dropped after re-enable", emitted, 4);
        chk(!overflow, "R9 no overflow with ready high", {31'd0, overflow}, 0);
        end_session();
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_stream();
        t_clamp();
        t_backpressure();
        t_timeout();
        t_reenable();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule